// File: doc/BRIEF.md
# Logic Self-Test Engine with Pseudo-Random Stimulus and Signature Compaction

This block runs a self-test on a combinational circuit placed beside it. After a start request it drives a stimulus word to the circuit on every test cycle. The stimulus comes either from a maximal-length linear-feedback shift register or from a binary up-counter that walks through every input combination. The circuit's response word comes back on every cycle. Any response bits flagged as unknown are forced to zero. The remaining bits are folded into a multiple-input signature register, which turns a long response stream into a short signature.

When the programmed number of patterns has been applied, the final signature is compared with a fault-free reference signature supplied at start. A single pass/fail verdict is raised together with a done flag. Both stay in place until the next start. The length, reference and stimulus mode are captured when a run is accepted. A start request that arrives during a run is ignored.

Top module: `lbist_ctrl`

## Requirements
- R1: After reset, busy, done and pass are 0, and signature and stim are all zero.
- R2: A start seen at a clock edge while busy is 0 is accepted: at that edge pat_count, golden_sig and mode_exh are captured and done and pass are cleared. A start seen while busy is 1 changes nothing: the run keeps its length and stimulus sequence.
- R3: After an accepted start with pat_count = N > 0, busy is 1 for exactly N consecutive cycles, starting the cycle after the start edge, and busy and done are never 1 together. With N = 0, busy stays 0 and done rises on the start edge with signature 0.
- R4: In shift-register mode (mode_exh = 0), stim is 8'h01 in the first busy cycle and then advances each cycle as s' = {s[6:0], s[7]^s[5]^s[4]^s[3]} for the default 8-bit width. It is never zero while busy, and it repeats after 255 steps.
- R5: In counter mode (mode_exh = 1), stim is 0 in the first busy cycle and then increases by one each cycle, wrapping from all ones to zero.
- R6: The signature register is cleared by an accepted start. On every busy cycle it takes sig' = {sig[14:0],1'b0} ^ (sig[15] ? 16'h1021 : 0) ^ {8'h00, resp & ~xmask}, where response bit b feeds signature bit b.
- R7: A response bit whose xmask bit is 1 in a cycle is forced to 0 before compaction, so its value has no effect on the signature.
- R8: done and pass change on the edge where busy falls. pass is 1 exactly when the final signature equals the golden_sig captured at start. done, pass and signature then hold until the next accepted start.
- R9: With a stuck-at fault present in the circuit under test, the final signature differs from the fault-free one and pass is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request, sampled while idle |
| mode_exh | input | 1 | 0 = shift-register stimulus, 1 = counter stimulus |
| pat_count | input | CNT_W | Number of patterns to apply |
| golden_sig | input | SIG_W | Fault-free reference signature |
| xmask | input | RSP_W | Per-bit unknown flags for the current response |
| resp | input | RSP_W | Response word from the circuit under test |
| stim | output | IN_W | Stimulus word to the circuit under test |
| busy | output | 1 | Patterns are being applied |
| done | output | 1 | Run finished, verdict valid |
| pass | output | 1 | Final signature matched the reference |
| signature | output | SIG_W | Current compacted signature |

## Verification
Two events can land on the same clock edge: a new start request and the compaction of the last pattern of a run in progress. The bench raises start during the final busy cycle and also in the middle of a run, with a different pattern count each time. It then expects busy to drop on schedule, done to rise with a verdict formed from the unchanged reference, and the signature to match the model of the original run. A later start taken from the held done state must clear the verdict and open a fresh run on the following cycle.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    // Feedback tap mask (bit i set = state bit i feeds the XOR) for a
    // maximal-length shift-left register of the given width.
    function automatic logic [31:0] lfsr_taps(input int width);
        case (width)
            3:       return 32'h0000_0006;
            4:       return 32'h0000_000C;
            5:       return 32'h0000_0014;
            6:       return 32'h0000_0030;
            7:       return 32'h0000_0060;
            8:       return 32'h0000_00B8;
            9:       return 32'h0000_0110;
            10:      return 32'h0000_0240;
            11:      return 32'h0000_0500;
            12:      return 32'h0000_0829;
            13:      return 32'h0000_100D;
            14:      return 32'h0000_2015;
            15:      return 32'h0000_6000;
            16:      return 32'h0000_D008;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/lbist_patgen.sv
module lbist_patgen
    import lbist_pkg::*;
#(
    parameter int IN_W   = 8,
    parameter bit EXH_EN = 1'b1,
    parameter int SEED   = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            adv,
    input  logic            mode_exh,
    output logic [IN_W-1:0] pat
);
    localparam logic [IN_W-1:0] TAPS = IN_W'(lfsr_taps(IN_W));

    typedef struct packed {
        logic            exh;
        logic [IN_W-1:0] pat;
    } gen_t;

    gen_t q, d;
    logic [IN_W-1:0] lfsr_nxt;
    logic [IN_W-1:0] cnt_nxt;
    logic            exh_sel;

    assign lfsr_nxt = {q.pat[IN_W-2:0], ^(q.pat & TAPS)};

    generate
        if (EXH_EN) begin : g_exh
            assign cnt_nxt = q.pat + IN_W'(1);
            assign exh_sel = mode_exh;
        end else begin : g_lfsr_only
            assign cnt_nxt = lfsr_nxt;
            assign exh_sel = 1'b0;
        end
    endgenerate

    always_comb begin
        d = q;
        if (load) begin
            d.exh = exh_sel;
            d.pat = exh_sel ? '0 : IN_W'(SEED);
        end else if (adv) begin
            d.pat = q.exh ? cnt_nxt : lfsr_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pat = q.pat;
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
    parameter int               RSP_W = 8,
    parameter int               SIG_W = 16,
    parameter logic [SIG_W-1:0] POLY  = 'h1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [RSP_W-1:0] resp,
    input  logic [RSP_W-1:0] xmask,
    output logic [SIG_W-1:0] sig_step,
    output logic [SIG_W-1:0] sig
);
    typedef struct packed {
        logic [SIG_W-1:0] sig;
    } misr_t;

    misr_t q, d;
    logic [RSP_W-1:0] gated;
    logic [SIG_W-1:0] folded;

    // Unknown bits are forced to zero, then wide responses fold onto the register.
    assign gated = resp & ~xmask;

    always_comb begin
        folded = '0;
        for (int b = 0; b < RSP_W; b++) begin
            folded[b % SIG_W] = folded[b % SIG_W] ^ gated[b];
        end
    end

    assign sig_step = {q.sig[SIG_W-2:0], 1'b0}
                    ^ (q.sig[SIG_W-1] ? POLY : '0)
                    ^ folded;

    always_comb begin
        d = q;
        if (clr)     d.sig = '0;
        else if (en) d.sig = sig_step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sig = q.sig;
endmodule

// File: rtl/lbist_seq.sv
module lbist_seq #(
    parameter int CNT_W = 16,
    parameter int SIG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] pat_count,
    input  logic [SIG_W-1:0] golden,
    input  logic [SIG_W-1:0] sig_step,
    output logic             load,
    output logic             adv,
    output logic             busy,
    output logic             done,
    output logic             pass
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic             pass;
        logic [CNT_W-1:0] left;
        logic [SIG_W-1:0] gold;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d    = q;
        load = 1'b0;
        adv  = 1'b0;
        if (start && !q.busy) begin
            load   = 1'b1;
            d.gold = golden;
            d.done = 1'b0;
            d.pass = 1'b0;
            if (pat_count == '0) begin
                d.done = 1'b1;
                d.pass = (golden == '0);
            end else begin
                d.busy = 1'b1;
                d.left = pat_count;
            end
        end else if (q.busy) begin
            adv    = 1'b1;
            d.left = q.left - CNT_W'(1);
            if (q.left == CNT_W'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.pass = (sig_step == q.gold);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign done = q.done;
    assign pass = q.pass;
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl #(
    parameter int               IN_W      = 8,
    parameter int               RSP_W     = 8,
    parameter int               SIG_W     = 16,
    parameter int               CNT_W     = 16,
    parameter bit               EXH_EN    = 1'b1,
    parameter int               LFSR_SEED = 1,
    parameter logic [SIG_W-1:0] MISR_POLY = 'h1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode_exh,
    input  logic [CNT_W-1:0] pat_count,
    input  logic [SIG_W-1:0] golden_sig,
    input  logic [RSP_W-1:0] xmask,
    input  logic [RSP_W-1:0] resp,
    output logic [IN_W-1:0]  stim,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic [SIG_W-1:0] signature
);
    logic             load;
    logic             adv;
    logic [SIG_W-1:0] sig_step;

    lbist_seq #(.CNT_W(CNT_W), .SIG_W(SIG_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .pat_count(pat_count),
        .golden   (golden_sig),
        .sig_step (sig_step),
        .load     (load),
        .adv      (adv),
        .busy     (busy),
        .done     (done),
        .pass     (pass)
    );

    lbist_patgen #(.IN_W(IN_W), .EXH_EN(EXH_EN), .SEED(LFSR_SEED)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .adv     (adv),
        .mode_exh(mode_exh),
        .pat     (stim)
    );

    lbist_misr #(.RSP_W(RSP_W), .SIG_W(SIG_W), .POLY(MISR_POLY)) u_misr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (load),
        .en      (adv),
        .resp    (resp),
        .xmask   (xmask),
        .sig_step(sig_step),
        .sig     (signature)
    );
endmodule

// File: rtl/lbist_ctrl_chk.sv
module lbist_ctrl_chk #(
    parameter int IN_W  = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             mode_exh,
    input logic [CNT_W-1:0] pat_count,
    input logic [IN_W-1:0]  stim,
    input logic             busy,
    input logic             done,
    input logic             pass
);
    logic             mode_rec;
    logic [CNT_W-1:0] len_rec;
    logic [CNT_W-1:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_rec <= 1'b0;
            len_rec  <= '0;
            busy_len <= '0;
        end else if (start && !busy) begin
            mode_rec <= mode_exh;
            len_rec  <= pat_count;
            busy_len <= '0;
        end else if (busy) begin
            busy_len <= busy_len + CNT_W'(1);
        end
    end

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R3
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == len_rec)); // R3
    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && pat_count != '0) |=> (busy && !done)); // R2
    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mode_rec) |-> (stim != '0)); // R4
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8
    AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done); // R8
    AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass))); // R8
endmodule

bind lbist_ctrl lbist_ctrl_chk #(.IN_W(IN_W), .CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode_exh (mode_exh),
    .pat_count(pat_count),
    .stim     (stim),
    .busy     (busy),
    .done     (done),
    .pass     (pass)
);

// File: tb/lbist_ctrl_tb.sv
module lbist_ctrl_tb_top;
    localparam int IN_W  = 8;
    localparam int RSP_W = 8;
    localparam int SIG_W = 16;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             mode_exh = 1'b0;
    logic [CNT_W-1:0] pat_count = '0;
    logic [SIG_W-1:0] golden_sig = '0;
    logic [RSP_W-1:0] xmask = '0;
    logic [RSP_W-1:0] xgarb = '0;
    logic             fault_en = 1'b0;
    logic [RSP_W-1:0] resp;
    logic [IN_W-1:0]  stim;
    logic             busy, done, pass;
    logic [SIG_W-1:0] signature;

    int checks = 0;
    int fails  = 0;
    logic [RSP_W-1:0] mask_arr [0:511];

    always #5 clk = ~clk;

    lbist_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_exh(mode_exh),
        .pat_count(pat_count), .golden_sig(golden_sig), .xmask(xmask),
        .resp(resp), .stim(stim), .busy(busy), .done(done), .pass(pass),
        .signature(signature)
    );

    // Example circuit under test; fault = output bit 3 stuck at 0.
    function automatic logic [7:0] cut_fn(input logic [7:0] s, input bit flt);
        logic [7:0] r;
        r = {s[7] & s[2], s[6] | s[1], s[5] ^ s[0], s[4] & ~s[3],
             s[3] ^ s[6], s[2] | s[7], ^s[3:0], s[0] & s[1]};
        if (flt) r[3] = 1'b0;
        return r;
    endfunction

    function automatic logic [7:0] lfsr_step(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic [15:0] misr_step(input logic [15:0] g, input logic [7:0] w);
        return {g[14:0], 1'b0} ^ (g[15] ? 16'h1021 : 16'h0000) ^ {8'h00, w};
    endfunction

    function automatic logic [15:0] calc_sig(input bit md, input int n, input bit flt);
        logic [7:0]  p;
        logic [15:0] g;
        p = md ? 8'h00 : 8'h01;
        g = '0;
        for (int i = 0; i < n; i++) begin
            g = misr_step(g, cut_fn(p, flt) & ~mask_arr[i]);
            p = md ? p + 8'h01 : lfsr_step(p);
        end
        return g;
    endfunction

    always_comb resp = (cut_fn(stim, fault_en) & ~xmask) | (xgarb & xmask);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One complete run; poke_at >= 0 raises start inside the run.
    task automatic run(input bit md, input int n, input logic [15:0] gold,
                       input bit flt, input int poke_at, output logic [15:0] sig_out);
        logic [7:0]  p;
        logic [15:0] g;
        @(negedge clk);
        start = 1'b1; mode_exh = md; pat_count = CNT_W'(n);
        golden_sig = gold; fault_en = flt;
        @(negedge clk);
        start = 1'b0;
        p = md ? 8'h00 : 8'h01;
        g = '0;
        for (int i = 0; i < n; i++) begin
            start = (i == poke_at);
            if (i == poke_at) begin
                pat_count = CNT_W'(3);
                mode_exh = ~md;
                golden_sig = ~gold;
            end
            chk(busy && !done, "R3", "busy window", {busy, done}, 2'b10);
            if (md) chk(stim == p, "R5", "counter stimulus", stim, p);
            else    chk(stim == p, "R4", "lfsr stimulus", stim, p);
            xmask = mask_arr[i];
            xgarb = RSP_W'($urandom);
            g = misr_step(g, cut_fn(p, flt) & ~mask_arr[i]);
            p = md ? p + 8'h01 : lfsr_step(p);
            @(negedge clk);
        end
        start = 1'b0;
        chk(!busy && done, "R3", "run end", {busy, done}, 2'b01);
        chk(signature == g, "R6", "final signature", signature, g);
        chk(pass == (g == gold), "R8", "verdict", pass, (g == gold));
        sig_out = g;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog: actual run hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] g, gf, s;
        logic        p0;
        void'($urandom(32'd1729));
        for (int i = 0; i < 512; i++) mask_arr[i] = RSP_W'($urandom & $urandom & $urandom);

        repeat (4) @(negedge clk);
        chk(!busy && !done && !pass, "R1", "reset flags", {busy, done, pass}, 3'b000);
        chk(signature == '0, "R1", "reset signature", signature, 0);
        chk(stim == '0, "R1", "reset stimulus", stim, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R6 R8: pseudo-random run with correct reference.
        g = calc_sig(1'b0, 60, 1'b0);
        run(1'b0, 60, g, 1'b0, -1, s);
        chk(pass, "R8", "matching reference passes", pass, 1);
        p0 = pass;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(done && pass == p0 && signature == s, "R8", "verdict held",
                {done, pass}, {1'b1, p0});
        end

        // R2 R4: long run past the 255-step period, start raised mid-run.
        g = calc_sig(1'b0, 300, 1'b0);
        run(1'b0, 300, g, 1'b0, 100, s);

        // R2 R5: counter wraps; start raised in the final busy cycle.
        g = calc_sig(1'b1, 260, 1'b0);
        run(1'b1, 260, g, 1'b0, 259, s);
        chk(pass, "R2", "final-cycle start ignored", pass, 1);

        // R8: wrong reference fails.
        g = calc_sig(1'b0, 30, 1'b0);
        run(1'b0, 30, g ^ 16'h0001, 1'b0, -1, s);
        chk(!pass, "R8", "mismatch fails", pass, 0);

        // R7: every bit unknown, garbage values must not reach the signature.
        for (int i = 0; i < 512; i++) mask_arr[i] = '1;
        run(1'b0, 40, 16'h0000, 1'b0, -1, s);
        chk(s == 16'h0000 && pass, "R7", "fully masked run", signature, 0);

        // R9: stuck-at fault detected.
        for (int i = 0; i < 512; i++) mask_arr[i] = '0;
        g  = calc_sig(1'b0, 200, 1'b0);
        gf = calc_sig(1'b0, 200, 1'b1);
        chk(gf != g, "R9", "fault changes signature", gf, ~g);
        run(1'b0, 200, g, 1'b1, -1, s);
        chk(!pass && signature != g, "R9", "fault reported", pass, 0);

        // R3: zero-length runs.
        run(1'b0, 0, 16'h0000, 1'b0, -1, s);
        chk(pass && signature == '0, "R3", "empty run good ref", pass, 1);
        run(1'b1, 0, 16'h0005, 1'b0, -1, s);
        chk(!pass, "R3", "empty run bad ref", pass, 0);

        // Mixed random runs with sparse unknown bits.
        for (int r = 0; r < 8; r++) begin
            bit md, flt, good;
            int n;
            for (int i = 0; i < 512; i++) mask_arr[i] = RSP_W'($urandom & $urandom);
            md   = 1'($urandom);
            flt  = 1'($urandom);
            good = 1'($urandom);
            n    = 1 + int'($urandom % 120);
            g    = calc_sig(md, n, 1'b0);
            run(md, n, good ? g : ~g, flt, (r % 3 == 0) ? n / 2 : -1, s);
            chk(s == calc_sig(md, n, flt), "R7", "masked random run", s, calc_sig(md, n, flt));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule